// File: doc/BRIEF.md
# Triple-Redundant Register Slice with Path Mismatch Flags

This block is one register stage of a pipeline that has been hardened against radiation effects on an FPGA. The stored word lives in three copies. Each copy has its own next-state selector: when that lane's write enable is set it takes the lane's new data, otherwise it takes the majority-voted value of the three copies. Every copy is therefore rewritten on every clock, so a flipped bit in one copy is repaired on the following edge instead of lingering until a second fault makes the vote wrong.

Three voters, one for each redundant output lane, form the bitwise majority of the copies and drive the protected outputs. Three comparators sit at the ends of the next-state paths, just in front of the copies. Each one compares one pair of lanes and raises its own flag as soon as the pair disagrees. An external controller uses a raised flag to reload the device configuration. The flags are not latched and they never touch the stored state, so the stage keeps running while reconfiguration is pending.

The surrounding logic drives the three data lanes and the three enables from triplicated logic. Each lane is used as the input of the next hardened stage.

Top module: `tmr_guard_reg`

## Requirements
- R1: A clock edge with `rst_n` low loads RST_VAL (default 0xA5) into all three copies, so from the next cycle `q_a`, `q_b` and `q_c` all read RST_VAL, whatever the data and enable inputs are.
- R2: With all three enables high and the three data lanes equal, all three outputs show that data from the cycle after the edge.
- R3: With all three enables low, the outputs keep their value from cycle to cycle.
- R4: When one lane differs from the other two, in its data or in its enable, all three outputs equal the value that the agreeing pair writes.
- R5: The vote is bitwise: if the three lanes write three different words, every output bit is the majority of the three written bits (for example 0xF0, 0xCC and 0xAA give 0xE8).
- R6: A copy whose enable is low reloads the voted value at that edge. A minority value written into one copy is therefore gone after one hold cycle. After that, a different minority value written into another copy does not change the outputs.
- R7: A wrong value held on one data lane for several consecutive write cycles never reaches the outputs, and after it ends the outputs follow the correct data with no residue.
- R8: The path of lane k is its data input when its enable is high and its voted output otherwise. `det[0]` flags a difference between the paths of lanes a and b, `det[1]` between lanes b and c, and `det[2]` between lanes c and a. A flag responds in the same cycle as the inputs, with no clock edge in between.
- R9: A flag is not held: it drops in the same cycle that its two paths agree again.
- R10: A raised flag has no effect on the stored state: the outputs after a flagged cycle are exactly what R2 to R6 predict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en_a | input | 1 | Write enable of lane a |
| wr_en_b | input | 1 | Write enable of lane b |
| wr_en_c | input | 1 | Write enable of lane c |
| d_in_a | input | WIDTH | New data, lane a |
| d_in_b | input | WIDTH | New data, lane b |
| d_in_c | input | WIDTH | New data, lane c |
| q_a | output | WIDTH | Voted output, lane a |
| q_b | output | WIDTH | Voted output, lane b |
| q_c | output | WIDTH | Voted output, lane c |
| det | output | 3 | Path mismatch flags: bit 0 is a/b, bit 1 is b/c, bit 2 is c/a |

## Verification
The stage is driven with clean writes and holds, which separate the write path from the feedback path. A single bad data lane and a single bad enable show that the majority wins, and each gives its own flag pattern. Three mutually different words show that the vote is taken bit by bit and not word by word. A minority write into lane a, then one hold cycle, then a different minority write into lane b with the same wrong word shows whether the feedback scrubs the copy: without scrubbing, the two wrong copies would outvote the good one. A three-cycle fault on one lane checks masking over time, and the cycle after it checks that the flags drop without being held.

// File: rtl/tmr_pkg.sv
// Shared constants for the triple-redundant register slice.
// Assumes exactly three lanes; lane order a, b, c maps to index 0, 1, 2.
package tmr_pkg;
    parameter int unsigned LANES = 3;

    // Index of the lane that lane k is compared against by its mismatch flag.
    function automatic int unsigned peer_lane(input int unsigned k);
        return (k + 1) % LANES;
    endfunction
endpackage

// File: rtl/tmr_lane_reg.sv
// One redundant copy of the stored word with its next-state selector.
// Assumes fb_in is the voted value for this lane; the copy is written every clock.
module tmr_lane_reg #(
    parameter int unsigned         WIDTH   = 8,
    parameter logic [WIDTH-1:0]    RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] d_in,
    input  logic [WIDTH-1:0] fb_in,
    output logic [WIDTH-1:0] nxt_out,
    output logic [WIDTH-1:0] q_out
);
    // Select new data on a write, otherwise recirculate the voted value.
    always_comb begin
        nxt_out = wr_en ? d_in : fb_in;
    end

    // Store the selected path; reset gives every copy the same value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_out <= RST_VAL;
        end else begin
            q_out <= nxt_out;
        end
    end
endmodule

// File: rtl/tmr_voter.sv
// Bitwise two-out-of-three majority of the three stored copies.
// Assumes all three inputs carry the same logical word.
module tmr_voter #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] in_x,
    input  logic [WIDTH-1:0] in_y,
    input  logic [WIDTH-1:0] in_z,
    output logic [WIDTH-1:0] vote
);
    // Each output bit follows whichever value at least two inputs hold.
    always_comb begin
        vote = (in_x & in_y) | (in_y & in_z) | (in_x & in_z);
    end
endmodule

// File: rtl/tmr_mismatch_det.sv
// Compares two redundant combinational paths and flags any difference.
// Assumes the flag is consumed asynchronously by a reconfiguration controller.
module tmr_mismatch_det #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] path_x,
    input  logic [WIDTH-1:0] path_y,
    output logic             flag
);
    // Flag at once whenever any bit of the two paths disagrees.
    always_comb begin
        flag = |(path_x ^ path_y);
    end
endmodule

// File: rtl/tmr_guard_reg.sv
// Triple-redundant register slice with voted feedback and pairwise path checks.
// Each lane has a copy, a selector and a voter; a comparator on each adjacent
// lane pair drives its own flag. Assumes triplicated upstream logic.
module tmr_guard_reg #(
    parameter int unsigned      WIDTH   = 8,
    parameter logic [WIDTH-1:0] RST_VAL = WIDTH'(8'hA5)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_a,
    input  logic             wr_en_b,
    input  logic             wr_en_c,
    input  logic [WIDTH-1:0] d_in_a,
    input  logic [WIDTH-1:0] d_in_b,
    input  logic [WIDTH-1:0] d_in_c,
    output logic [WIDTH-1:0] q_a,
    output logic [WIDTH-1:0] q_b,
    output logic [WIDTH-1:0] q_c,
    output logic [2:0]       det
);
    import tmr_pkg::*;

    logic [LANES-1:0]            wr_vec;
    logic [LANES-1:0][WIDTH-1:0] d_vec;
    logic [LANES-1:0][WIDTH-1:0] copy_q;
    logic [LANES-1:0][WIDTH-1:0] voted;
    logic [LANES-1:0][WIDTH-1:0] path;

    // Gather the lane inputs into indexed vectors.
    always_comb begin
        wr_vec = {wr_en_c, wr_en_b, wr_en_a};
        d_vec  = {d_in_c, d_in_b, d_in_a};
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        tmr_lane_reg #(
            .WIDTH   (WIDTH),
            .RST_VAL (RST_VAL)
        ) u_copy (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_vec[k]),
            .d_in    (d_vec[k]),
            .fb_in   (voted[k]),
            .nxt_out (path[k]),
            .q_out   (copy_q[k])
        );

        tmr_voter #(
            .WIDTH (WIDTH)
        ) u_vote (
            .in_x (copy_q[0]),
            .in_y (copy_q[1]),
            .in_z (copy_q[2]),
            .vote (voted[k])
        );

        tmr_mismatch_det #(
            .WIDTH (WIDTH)
        ) u_det (
            .path_x (path[k]),
            .path_y (path[peer_lane(k)]),
            .flag   (det[k])
        );
    end

    // Drive the protected outputs from the per-lane voters.
    always_comb begin
        q_a = voted[0];
        q_b = voted[1];
        q_c = voted[2];
    end
endmodule

// File: rtl/tmr_guard_reg_chk.sv
// Property checker for tmr_guard_reg, attached by bind below.
// Observes the ports and the stored copies; drives nothing.
module tmr_guard_reg_chk #(
    parameter int unsigned      WIDTH   = 8,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en_a,
    input logic                  wr_en_b,
    input logic                  wr_en_c,
    input logic [WIDTH-1:0]      d_in_a,
    input logic [WIDTH-1:0]      d_in_b,
    input logic [WIDTH-1:0]      d_in_c,
    input logic [WIDTH-1:0]      q_a,
    input logic [WIDTH-1:0]      q_b,
    input logic [WIDTH-1:0]      q_c,
    input logic [2:0]            det,
    input logic [2:0][WIDTH-1:0] copy_q
);
    p_reset_load_r1: assert property (@(posedge clk)
        !rst_n |=> (copy_q[0] == RST_VAL && copy_q[1] == RST_VAL && copy_q[2] == RST_VAL));

    p_clean_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_a && wr_en_b && wr_en_c && d_in_a == d_in_b && d_in_b == d_in_c)
        |=> (q_a == $past(d_in_a)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_a && !wr_en_b && !wr_en_c) |=> $stable(q_a));

    p_lanes_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q_a == q_b) && (q_b == q_c));

    p_scrub_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_b |=> (copy_q[1] == $past(q_b)));

    p_quiet_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_a && wr_en_b && d_in_a == d_in_b) |-> !det[0]);
endmodule

bind tmr_guard_reg tmr_guard_reg_chk #(
    .WIDTH   (WIDTH),
    .RST_VAL (RST_VAL)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_a (wr_en_a),
    .wr_en_b (wr_en_b),
    .wr_en_c (wr_en_c),
    .d_in_a  (d_in_a),
    .d_in_b  (d_in_b),
    .d_in_c  (d_in_c),
    .q_a     (q_a),
    .q_b     (q_b),
    .q_c     (q_c),
    .det     (det),
    .copy_q  (copy_q)
);

// File: tb/tmr_guard_reg_tb.sv
// Bench for tmr_guard_reg: a behavioural model of three copies is stepped
// every clock and compared against the outputs and flags.
module tmr_guard_reg_tb;
    localparam int unsigned W = 8;
    localparam logic [W-1:0] RV = 8'hA5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en_a = 1'b0, wr_en_b = 1'b0, wr_en_c = 1'b0;
    logic [W-1:0] d_in_a = '0, d_in_b = '0, d_in_c = '0;
    logic [W-1:0] q_a, q_b, q_c;
    logic [2:0]   det;

    int           n_cmp = 0;
    int           n_bad = 0;
    bit           armed = 1'b0;
    string        cur_req = "R1";
    int           mdl [3];

    tmr_guard_reg #(.WIDTH(W), .RST_VAL(RV)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en_a(wr_en_a), .wr_en_b(wr_en_b), .wr_en_c(wr_en_c),
        .d_in_a(d_in_a), .d_in_b(d_in_b), .d_in_c(d_in_c),
        .q_a(q_a), .q_b(q_b), .q_c(q_c), .det(det)
    );

    always #2 clk = ~clk;

    // Per-bit majority by counting ones.
    function automatic int majority(input int x, input int y, input int z);
        int r = 0;
        for (int i = 0; i < W; i++) begin
            int ones = ((x >> i) & 1) + ((y >> i) & 1) + ((z >> i) & 1);
            if (ones >= 2) r = r | (1 << i);
        end
        return r;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, compare, advance the model.
    task automatic step(input bit rn, input bit [2:0] we,
                        input int da, input int db, input int dc);
        int v, p [3], ed;
        int dd [3];
        @(negedge clk);
        rst_n = rn;
        {wr_en_c, wr_en_b, wr_en_a} = we;
        d_in_a = W'(da); d_in_b = W'(db); d_in_c = W'(dc);
        dd[0] = da; dd[1] = db; dd[2] = dc;
        #1;
        v = majority(mdl[0], mdl[1], mdl[2]);
        for (int k = 0; k < 3; k++) p[k] = we[k] ? dd[k] : v;
        ed = 0;
        for (int k = 0; k < 3; k++) if (p[k] != p[(k + 1) % 3]) ed = ed | (1 << k);
        if (armed) begin
            check(cur_req, "q_a", int'(q_a), v);
            check(cur_req, "q_b", int'(q_b), v);
            check(cur_req, "q_c", int'(q_c), v);
            if (rn) check((cur_req == "R9") ? "R9" : "R8", "det", int'(det), ed);
        end
        for (int k = 0; k < 3; k++) mdl[k] = !rn ? int'(RV) : p[k];
        @(posedge clk);
        armed = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 3; k++) mdl[k] = 0;
        // R1: reset wins over a write request
        cur_req = "R1";
        step(0, 3'b111, 'h33, 'h33, 'h33);
        step(0, 3'b111, 'h33, 'h33, 'h33);
        step(1, 3'b000, 'h00, 'h00, 'h00);
        // R2: clean writes
        cur_req = "R2";
        step(1, 3'b111, 'h3C, 'h3C, 'h3C);
        step(1, 3'b111, 'hC3, 'hC3, 'hC3);
        step(1, 3'b000, 'h00, 'h00, 'h00);
        // R3: hold with junk on data lanes
        cur_req = "R3";
        step(1, 3'b000, 'hFF, 'h12, 'h80);
        step(1, 3'b000, 'h01, 'h02, 'h03);
        step(1, 3'b000, 'h00, 'h00, 'h00);
        // R4: one bad data lane, then one bad enable
        cur_req = "R4";
        step(1, 3'b111, 'hFF, 'h11, 'h11);
        step(1, 3'b110, 'h22, 'h22, 'h22);
        step(1, 3'b000, 'h00, 'h00, 'h00);
        // R5: three different words, bitwise vote gives E8
        cur_req = "R5";
        step(1, 3'b111, 'hF0, 'hCC, 'hAA);
        step(1, 3'b000, 'h00, 'h00, 'h00);
        // R6: minority into a, one hold, minority into b with the same word
        cur_req = "R6";
        step(1, 3'b111, 'h55, 'h55, 'h55);
        step(1, 3'b001, 'hAA, 'h00, 'h00);
        step(1, 3'b000, 'h00, 'h00, 'h00);
        step(1, 3'b010, 'h00, 'hAA, 'h00);
        step(1, 3'b000, 'h00, 'h00, 'h00);
        step(1, 3'b000, 'h00, 'h00, 'h00);
        // R7: lane c stuck low for three writes
        cur_req = "R7";
        step(1, 3'b111, 'h12, 'h12, 'h00);
        step(1, 3'b111, 'h34, 'h34, 'h00);
        step(1, 3'b111, 'h56, 'h56, 'h00);
        step(1, 3'b111, 'h78, 'h78, 'h78);
        step(1, 3'b000, 'h00, 'h00, 'h00);
        // R9: flag raised one cycle, gone the next
        cur_req = "R9";
        step(1, 3'b111, 'h9A, 'h9B, 'h9A);
        step(1, 3'b111, 'h9A, 'h9A, 'h9A);
        step(1, 3'b000, 'h00, 'h00, 'h00);
        // R10: stored state after flagged cycles follows the model
        cur_req = "R10";
        step(1, 3'b011, 'h44, 'h44, 'hEE);
        step(1, 3'b000, 'h00, 'h00, 'h00);
        step(1, 3'b000, 'h00, 'h00, 'h00);
        // R1: reset again from a non-reset value
        cur_req = "R1";
        step(0, 3'b000, 'h00, 'h00, 'h00);
        step(1, 3'b000, 'h00, 'h00, 'h00);
        step(1, 3'b000, 'h00, 'h00, 'h00);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule